// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Fill Threshold

This block sits between a memory-mapped register port and a serial slot engine in an audio path. It holds two sample queues: one carries words from the bus toward the slot engine (transmit), the other carries words captured by the slot engine back to the bus (receive). Each queue raises a DMA request line that follows its fill level against a programmable threshold. A DMA controller can then move bursts of up to 16 words of 32 bits without polling.

Each direction has its own control word. That word holds a write-one queue flush, a DMA enable and a 4-bit threshold. One data-window address serves both directions: a bus write there queues a transmit word and a bus read there takes a receive word. Error and request events are collected in a 7-bit sticky status register that is cleared by writing ones. An enable register selects which status bits drive the interrupt line.

Top module: `aud_fifo_dma`

## Requirements
- R1: After reset, both control words read 0x20 (threshold 8 in bits 5:2, DMA enable bit 1 clear, flush bit 0 clear). Both queues are empty, status and enable read 0, and irq, tx_dreq, rx_dreq and tx_avail are low.
- R2: Writing a control word with bit 0 set empties that queue in the same write, and the new enable and threshold from the same write take effect. Bit 0 always reads back as 0.
- R3: While a direction's DMA enable (control bit 1) is clear, its request line stays low whatever the fill level.
- R4: With enable set, tx_dreq is high exactly when the transmit queue holds no more than threshold words.
- R5: With enable set, rx_dreq is high exactly when the receive queue holds at least threshold words.
- R6: Both queues are first-in first-out. A bus write to the data window (offset 0x10) queues a transmit word, and tx_data shows the oldest transmit word while tx_avail is high; tx_pop removes it. A bus read of the data window removes the oldest receive word and returns it on reg_rdata in the cycle after the read strobe.
- R7: Each queue holds 32 words. A push to a full queue leaves its contents unchanged and sets status bit 0 (transmit) or bit 2 (receive).
- R8: A pop from an empty queue leaves it empty and sets status bit 1 (tx_pop on empty transmit) or bit 3 (bus read on empty receive, which returns 0).
- R9: Writing the status register (offset 0x0C) clears each bit written as 1 and leaves the others. A bit whose event occurs in the same cycle as its clear write stays set.
- R10: irq is high exactly when some status bit is set whose enable bit (offset 0x08) is set.
- R11: Status bit 4 is set when tx_dreq goes from low to high and bit 5 when rx_dreq does. Bit 6 is never set. The control words are at offsets 0x00 (transmit) and 0x04 (receive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Single-cycle register read strobe |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| tx_pop | input | 1 | Slot engine takes the oldest transmit word |
| tx_data | output | DATA_W | Oldest transmit word |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Slot engine delivers a received word |
| rx_data | input | DATA_W | Received word |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in one cycle: an event that sets a status bit, and a bus write that clears that same bit. The bench provokes this by pulsing tx_pop on an empty transmit queue in the same cycle as a write of 1 to status bit 1. It then reads the status back and expects the bit still set with irq high, and expects a later lone clear to drop both. The threshold compare is swept over every threshold value and every fill level from 0 to 32 in both directions, with the expected request computed from the count the bench itself has pushed.

// File: rtl/aud_fifo_pkg.sv
// Shared constants for the audio sample FIFO pair.
// Assumes byte addressing with 32-bit registers at 4-byte steps.
package aud_fifo_pkg;
    localparam int REG_AW     = 5;
    localparam logic [REG_AW-1:0] OFS_TXCTL = 5'h00;
    localparam logic [REG_AW-1:0] OFS_RXCTL = 5'h04;
    localparam logic [REG_AW-1:0] OFS_IEN   = 5'h08;
    localparam logic [REG_AW-1:0] OFS_ISTAT = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_DBUF  = 5'h10;

    // control word layout
    localparam int CTL_FLUSH  = 0;
    localparam int CTL_DMA    = 1;
    localparam int CTL_THR_LO = 2;
    localparam int THR_W      = 4;
    localparam logic [THR_W-1:0] THR_RESET = 4'd8;

    // status bit positions
    localparam int ST_TX_OVF = 0;
    localparam int ST_TX_UNF = 1;
    localparam int ST_RX_OVF = 2;
    localparam int ST_RX_UNF = 3;
    localparam int ST_TX_REQ = 4;
    localparam int ST_RX_REQ = 5;
    localparam int ST_SPARE  = 6;
    localparam int ST_W      = 7;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int N_DIR  = 2;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             dma_en;
    } dir_ctl_t;
endpackage

// File: rtl/smp_fifo.sv
// Synchronous sample queue with first-word fall-through head.
// Assumes DEPTH is a power of two. A push is taken only when not full,
// a pop only when not empty, both judged on the state before the edge.
// clr empties the queue and overrides push and pop in that cycle.
module smp_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty,
    output logic              ovf,
    output logic              unf
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign ovf     = push && full && !clr;
    assign unf     = pop && empty && !clr;
    assign rdata   = mem[rd_ptr];

    // storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));
    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (count == '0));
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/req_level.sv
// DMA request from fill level. FILL_SIDE=0 (drain side, transmit) asks
// while count <= thr; FILL_SIDE=1 (fill side, receive) asks while
// count >= thr. Assumes the count is at least as wide as the threshold.
module req_level #(
    parameter int CW        = 6,
    parameter int THR_W     = 4,
    parameter bit FILL_SIDE = 1'b0
) (
    input  logic             en,
    input  logic [CW-1:0]    count,
    input  logic [THR_W-1:0] thr,
    output logic             req
);
    logic [CW-1:0] thr_x;
    logic          hit;

    assign thr_x = {{(CW-THR_W){1'b0}}, thr};

    generate
        if (FILL_SIDE) begin : g_fill
            assign hit = (count >= thr_x);
        end else begin : g_drain
            assign hit = (count <= thr_x);
        end
    endgenerate

    assign req = en && hit;
endmodule

// File: rtl/irq_ctl.sv
// Sticky interrupt status with write-one-to-clear and an enable mask.
// Assumes set events are single-cycle pulses; a set in the same cycle
// as its clear keeps the bit set.
module irq_ctl #(
    parameter int ST_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_ev,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_mask,
    input  logic            en_wr,
    input  logic [ST_W-1:0] en_data,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] enable,
    output logic            irq
);
    logic [ST_W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;
    assign irq     = |(status & enable);

    // status bits: clear written ones, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set_ev;
    end

    // interrupt enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_wr) enable <= en_data;
    end

    a_r9_set_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev != '0) |=> ((status & $past(set_ev)) == $past(set_ev)));
    a_r9_clear_only_written: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && set_ev == '0) |=>
            ((status & $past(clr_mask)) == '0) &&
            ((status & ~$past(clr_mask)) == ($past(status) & ~$past(clr_mask))));
endmodule

// File: rtl/aud_fifo_dma.sv
// Transmit and receive sample queues with threshold DMA requests and
// interrupt status. Register port uses single-cycle strobes; reads return
// data registered one cycle after reg_rd. One data window serves both
// directions: write queues transmit, read takes receive.
module aud_fifo_dma
    import aud_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_avail,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              irq
);
    dir_ctl_t          ctl_q   [N_DIR];
    logic              ctl_wr  [N_DIR];
    logic              f_clr   [N_DIR];
    logic              f_push  [N_DIR];
    logic              f_pop   [N_DIR];
    logic [DATA_W-1:0] f_wdata [N_DIR];
    logic [DATA_W-1:0] f_rdata [N_DIR];
    logic [CW-1:0]     f_count [N_DIR];
    logic              f_full  [N_DIR];
    logic              f_empty [N_DIR];
    logic              f_ovf   [N_DIR];
    logic              f_unf   [N_DIR];
    logic              dreq    [N_DIR];
    logic              dreq_d  [N_DIR];
    logic [ST_W-1:0]   set_ev;
    logic [ST_W-1:0]   status;
    logic [ST_W-1:0]   enable;
    logic              dbuf_wr;
    logic              dbuf_rd;

    assign dbuf_wr        = reg_wr && (reg_addr == OFS_DBUF);
    assign dbuf_rd        = reg_rd && (reg_addr == OFS_DBUF);
    assign ctl_wr[DIR_TX] = reg_wr && (reg_addr == OFS_TXCTL);
    assign ctl_wr[DIR_RX] = reg_wr && (reg_addr == OFS_RXCTL);

    assign f_push[DIR_TX]  = dbuf_wr;
    assign f_wdata[DIR_TX] = reg_wdata;
    assign f_pop[DIR_TX]   = tx_pop;
    assign f_push[DIR_RX]  = rx_push;
    assign f_wdata[DIR_RX] = rx_data;
    assign f_pop[DIR_RX]   = dbuf_rd;

    generate
        for (genvar d = 0; d < N_DIR; d++) begin : g_dir
            assign f_clr[d] = ctl_wr[d] && reg_wdata[CTL_FLUSH];

            // per-direction control word (flush bit is not stored)
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl_q[d].thr    <= THR_RESET;
                    ctl_q[d].dma_en <= 1'b0;
                end else if (ctl_wr[d]) begin
                    ctl_q[d].thr    <= reg_wdata[CTL_THR_LO +: THR_W];
                    ctl_q[d].dma_en <= reg_wdata[CTL_DMA];
                end
            end

            // previous request level for rise detection
            always_ff @(posedge clk) begin
                if (!rst_n) dreq_d[d] <= 1'b0;
                else        dreq_d[d] <= dreq[d];
            end

            smp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (f_clr[d]),
                .push  (f_push[d]),
                .wdata (f_wdata[d]),
                .pop   (f_pop[d]),
                .rdata (f_rdata[d]),
                .count (f_count[d]),
                .full  (f_full[d]),
                .empty (f_empty[d]),
                .ovf   (f_ovf[d]),
                .unf   (f_unf[d])
            );

            req_level #(.CW(CW), .THR_W(THR_W), .FILL_SIDE(d == DIR_RX)) u_req (
                .en    (ctl_q[d].dma_en),
                .count (f_count[d]),
                .thr   (ctl_q[d].thr),
                .req   (dreq[d])
            );

            a_r3_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
                dreq[d] |-> ctl_q[d].dma_en);
        end
    endgenerate

    always_comb begin
        set_ev            = '0;
        set_ev[ST_TX_OVF] = f_ovf[DIR_TX];
        set_ev[ST_TX_UNF] = f_unf[DIR_TX];
        set_ev[ST_RX_OVF] = f_ovf[DIR_RX];
        set_ev[ST_RX_UNF] = f_unf[DIR_RX];
        set_ev[ST_TX_REQ] = dreq[DIR_TX] && !dreq_d[DIR_TX];
        set_ev[ST_RX_REQ] = dreq[DIR_RX] && !dreq_d[DIR_RX];
        set_ev[ST_SPARE]  = 1'b0;
    end

    irq_ctl #(.ST_W(ST_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .clr_wr   (reg_wr && (reg_addr == OFS_ISTAT)),
        .clr_mask (reg_wdata[ST_W-1:0]),
        .en_wr    (reg_wr && (reg_addr == OFS_IEN)),
        .en_data  (reg_wdata[ST_W-1:0]),
        .status   (status),
        .enable   (enable),
        .irq      (irq)
    );

    // registered read mux; data-window read returns the head being popped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= '0;
            case (reg_addr)
                OFS_TXCTL: reg_rdata[CTL_THR_LO+THR_W-1:CTL_DMA] <= {ctl_q[DIR_TX].thr, ctl_q[DIR_TX].dma_en};
                OFS_RXCTL: reg_rdata[CTL_THR_LO+THR_W-1:CTL_DMA] <= {ctl_q[DIR_RX].thr, ctl_q[DIR_RX].dma_en};
                OFS_IEN:   reg_rdata[ST_W-1:0] <= enable;
                OFS_ISTAT: reg_rdata[ST_W-1:0] <= status;
                OFS_DBUF:  reg_rdata <= f_empty[DIR_RX] ? '0 : f_rdata[DIR_RX];
                default:   reg_rdata <= '0;
            endcase
        end
    end

    assign tx_data  = f_rdata[DIR_TX];
    assign tx_avail = !f_empty[DIR_TX];
    assign tx_dreq  = dreq[DIR_TX];
    assign rx_dreq  = dreq[DIR_RX];

    a_r8_rx_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_rd && f_empty[DIR_RX]) |=> (reg_rdata == '0));
    a_r11_spare_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_SPARE]);
endmodule

// File: tb/sim_aud_fifo_dma.sv
module sim_aud_fifo_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0;
    logic [31:0] tx_data;
    logic        tx_avail;
    logic        rx_push = 1'b0;
    logic [31:0] rx_data = '0;
    logic        tx_dreq;
    logic        rx_dreq;
    logic        irq;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    aud_fifo_dma u0 (.*);

    function automatic logic [31:0] seed(int a, int b);
        return {a[15:0], b[15:0]} ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_tx_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic pulse_rx(input logic [31:0] d);
        @(negedge clk); rx_push = 1'b1; rx_data = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); chk("R1 txctl", v, 32'h20);
        rd(5'h04, v); chk("R1 rxctl", v, 32'h20);
        rd(5'h0C, v); chk("R1 status", v, 0);
        rd(5'h08, v); chk("R1 enable", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tx_avail", tx_avail, 0);
        chk("R3 tx_dreq off at count 0", tx_dreq, 0);
        chk("R1 rx_dreq", rx_dreq, 0);

        // R4 R6 R7 transmit sweep
        for (int t = 0; t < 16; t++) begin
            wr(5'h00, (t << 2) | 3);
            for (int n = 0; n <= 32; n++) begin
                chk("R4 tx_dreq", tx_dreq, (n <= t));
                chk("R6 tx_avail", tx_avail, (n > 0));
                if (n < 32) wr(5'h10, seed(t, n));
            end
            wr(5'h0C, 32'h7F);
            wr(5'h10, 32'hDEAD_BEEF);
            rd(5'h0C, v); chk("R7 tx overflow bit0", v & 1, 1);
            for (int k = 0; k < 32; k++) begin
                chk("R6 R7 tx order", tx_data, seed(t, k));
                pulse_tx_pop();
            end
            chk("R6 tx drained", tx_avail, 0);
            wr(5'h0C, 32'h7F);
            pulse_tx_pop();
            rd(5'h0C, v); chk("R8 tx underflow bit1", v & 2, 2);
            chk("R8 tx still empty", tx_avail, 0);
        end

        // R2 flush with new fields
        wr(5'h10, 32'h1); wr(5'h10, 32'h2); wr(5'h10, 32'h3);
        chk("R2 pre-flush", tx_avail, 1);
        wr(5'h00, (5 << 2) | 1);
        chk("R2 flushed", tx_avail, 0);
        rd(5'h00, v); chk("R2 fields, flush reads 0", v, 32'h14);
        chk("R3 disabled after flush", tx_dreq, 0);

        // R5 R6 R7 R8 receive sweep
        for (int t = 0; t < 16; t++) begin
            wr(5'h04, (t << 2) | 3);
            for (int n = 0; n <= 32; n++) begin
                chk("R5 rx_dreq", rx_dreq, (n >= t));
                if (n < 32) pulse_rx(seed(t + 40, n));
            end
            wr(5'h0C, 32'h7F);
            pulse_rx(32'hCAFE_F00D);
            rd(5'h0C, v); chk("R7 rx overflow bit2", v & 4, 4);
            for (int k = 0; k < 32; k++) begin
                rd(5'h10, v); chk("R6 R7 rx order", v, seed(t + 40, k));
            end
            wr(5'h0C, 32'h7F);
            rd(5'h10, v); chk("R8 rx empty read", v, 0);
            rd(5'h0C, v); chk("R8 rx underflow bit3", v & 8, 8);
        end
        wr(5'h04, 32'h20);
        chk("R3 rx disabled", rx_dreq, 0);

        // R9 R10 set and clear in one cycle
        wr(5'h00, 32'h20);
        wr(5'h0C, 32'h7F);
        wr(5'h08, 32'h02);
        chk("R10 irq idle", irq, 0);
        pulse_tx_pop();
        chk("R10 irq on enabled bit", irq, 1);
        @(negedge clk);
        tx_pop = 1'b1; reg_wr = 1'b1; reg_addr = 5'h0C; reg_wdata = 32'h2;
        @(negedge clk);
        tx_pop = 1'b0; reg_wr = 1'b0;
        rd(5'h0C, v); chk("R9 set beats clear", v & 2, 2);
        chk("R10 irq kept", irq, 1);
        wr(5'h0C, 32'h2);
        rd(5'h0C, v); chk("R9 lone clear", v, 0);
        chk("R10 irq dropped", irq, 0);
        pulse_tx_pop();
        wr(5'h08, 32'h01);
        chk("R10 masked bit no irq", irq, 0);
        wr(5'h0C, 32'h7F);

        // R11 request rise events
        wr(5'h00, 32'h02);
        wr(5'h04, 32'h02);
        rd(5'h0C, v);
        chk("R11 tx rise bit4", v & 32'h10, 32'h10);
        chk("R11 rx rise bit5", v & 32'h20, 32'h20);
        chk("R11 spare bit6", v & 32'h40, 0);
        wr(5'h0C, 32'h7F);
        wr(5'h00, 32'h02);
        rd(5'h0C, v); chk("R11 no rise while high", v & 32'h10, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule